// File: doc/BRIEF.md
# Bus-Attached ROM Emulator with Clock and Reset Source

This block stands in for the read-only memory of an 8-bit processor system, and also acts as that processor's clock and reset source. It holds a writable byte image. It watches the CPU's 16-bit address bus and its read/write line. It drives the data bus only when the upper half of the address space is addressed, the cycle is a read and the CPU clock is in its high phase. Address bit 15 alone is the chip select. When that bit is low the block keeps off the bus, so an external RAM selected by the same wire can answer.

The CPU clock (`phi2`) comes from a programmable divider of the system clock, and each phase lasts a whole number of system cycles. The reset line is open-drain: the block either pulls it low or releases it, and an external pull-up raises it. The pad-level tri-state drivers are outside the block. At power-up the block keeps the CPU in reset with the clock stopped and the bus undriven. When the host link is present it starts the clock, enables serving and releases reset by itself.

The host can then hold the CPU in reset to load a new image through a simple write port. The image is volatile and holds undefined data until it is loaded. With the default divider the clock period is about five seconds at a 100 MHz system clock, which lets the CPU be stepped by hand.

Top module: `bus_rom_emulator`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it, `phi2` is 0, `resb_pull_low` is 1 (CPU held in reset) and `cpu_data_oe` is 0.
- R2: The first time `link_up` is sampled high with `host_hold_rst` low, `resb_pull_low` is 0 one cycle later and `phi2` begins toggling. No other command is needed.
- R3: With a nonzero divider value N loaded through `div_we`/`div_val`, every high phase and every low phase of `phi2` lasts exactly N system clock cycles. After reset the divider holds `DIV_DEFAULT`.
- R4: With a divider value of 0, `phi2` is low from the second cycle after the write and stays low.
- R5: When `cpu_addr[15]`=1, `cpu_rwb`=1 (read) and `phi2`=1 are sampled at a clock edge after start-up, `cpu_data_oe` is 1 one cycle later. At the same time `cpu_data_o` equals the image byte at index `cpu_addr[IMG_AW-1:0]`.
- R6: When `cpu_addr[15]`=0 is sampled, `cpu_data_oe` is 0 one cycle later.
- R7: When `cpu_rwb`=0 (write) or `phi2`=0 is sampled, `cpu_data_oe` is 0 one cycle later.
- R8: `host_hold_rst` high sampled at an edge makes `resb_pull_low` 1 one cycle later. Dropping it after start-up makes `resb_pull_low` 0 one cycle later.
- R9: A write strobe on `img_we` changes the image only when `resb_pull_low` is 1 in that cycle. A strobe while reset is released has no effect.
- R10: The image holds 2^`IMG_AW` bytes and is mirrored across 0x8000–0xFFFF. Addresses that differ only in bits `IMG_AW`..14 return the same byte. With `IMG_AW`=15 it fills the whole 32 KB window.
- R11: Before `link_up` has ever been sampled high, `phi2` stays 0 and `cpu_data_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_up | input | 1 | Host link present |
| host_hold_rst | input | 1 | Host request to hold the CPU in reset |
| div_we | input | 1 | Load strobe for the clock divider |
| div_val | input | DIV_W | Half-period of `phi2` in system cycles; 0 stops the clock |
| img_we | input | 1 | Image write strobe |
| img_addr | input | IMG_AW | Image write index |
| img_data | input | 8 | Image write byte |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rwb | input | 1 | CPU read/write line, 1 = read |
| cpu_data_o | output | 8 | Byte for the CPU data bus |
| cpu_data_oe | output | 1 | Data bus drive enable, 0 = high impedance |
| phi2 | output | 1 | CPU clock |
| resb_pull_low | output | 1 | 1 pulls the CPU reset line low, 0 releases it |

## Verification
Every bus and reset result is due exactly one system cycle after the inputs that cause it. The bench drives on a falling edge and records the `phi2` value at that moment, since that value feeds the next rising edge. It checks enable and data at the following falling edge against a reference image kept in the bench. The `phi2` phases are measured by counting falling-edge samples between transitions, after the divider has settled. The stop case allows two cycles, because a toggle already decided by the old divider can still land on the write edge.

// File: rtl/romemu_pkg.sv
// Shared constants and types for the bus ROM emulator.
// Assumes an 8-bit data bus and a 16-bit CPU address bus.
package romemu_pkg;
    localparam int unsigned CPU_AW = 16;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned SEL_BIT = CPU_AW - 1;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [CPU_AW-1:0] cpu_addr_t;
endpackage

// File: rtl/romemu_phi2gen.sv
// CPU clock generator: phi2 toggles every div_q system cycles while run is high.
// Assumes run is sticky once set; a zero divider parks phi2 low.
module romemu_phi2gen #(
    parameter int unsigned DIV_W       = 28,
    parameter int unsigned DIV_DEFAULT = 250_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_val,
    output logic             phi2
);
    localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(DIV_DEFAULT);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;
    logic             phi2_q;
    logic             last_cnt;

    assign last_cnt = (cnt_q == div_q - 1'b1);

    // Divider register, loaded by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= DIV_RST;
        else if (div_we) div_q <= div_val;
    end

    // Phase counter and phi2 toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            phi2_q <= 1'b0;
        end else if (!run || div_q == '0) begin
            cnt_q  <= '0;
            phi2_q <= 1'b0;
        end else if (div_we) begin
            cnt_q <= '0;
        end else if (last_cnt) begin
            cnt_q  <= '0;
            phi2_q <= ~phi2_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign phi2 = phi2_q;

    // R4
    phi2_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == '0) |=> !phi2_q);

    // R3
    phi2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && div_q != '0 && !last_cnt) |=> $stable(phi2_q));
endmodule

// File: rtl/romemu_rstseq.sv
// Start-up and reset sequencing: latches the first sight of the host link,
// then releases the CPU reset unless the host asks to hold it.
module romemu_rstseq (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up,
    input  logic host_hold,
    output logic started,
    output logic rst_assert
);
    logic started_q;
    logic rst_q;
    logic started_nx;

    assign started_nx = started_q | link_up;

    // Sticky start flag and registered open-drain reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            rst_q     <= 1'b1;
        end else begin
            started_q <= started_nx;
            rst_q     <= !started_nx || host_hold;
        end
    end

    assign started    = started_q;
    assign rst_assert = rst_q;

    // R2
    autostart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && !host_hold) |=> !rst_q);

    // R8
    hold_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_hold |=> rst_q);
endmodule

// File: rtl/romemu_image.sv
// Volatile image store: one write port, one registered read port.
// Assumes contents are undefined until written; no reset on the array.
module romemu_image #(
    parameter int unsigned IMG_AW = 11
) (
    input  logic                       clk,
    input  logic                       wr_en,
    input  logic [IMG_AW-1:0]          wr_addr,
    input  romemu_pkg::byte_t          wr_data,
    input  logic [IMG_AW-1:0]          rd_addr,
    output romemu_pkg::byte_t          rd_data
);
    localparam int unsigned DEPTH = 1 << IMG_AW;

    romemu_pkg::byte_t mem [DEPTH];
    romemu_pkg::byte_t rd_q;

    // Store a host byte.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Fetch the byte for the current bus address.
    always_ff @(posedge clk) begin
        rd_q <= mem[rd_addr];
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/bus_rom_emulator.sv
// Top of the ROM emulator: bit 15 of the CPU address selects the image,
// which is served during read cycles in the high phase of phi2.
// Assumes pad-level tri-state and the reset pull-up are outside the block.
module bus_rom_emulator #(
    parameter int unsigned IMG_AW      = 11,
    parameter int unsigned DIV_W       = 28,
    parameter int unsigned DIV_DEFAULT = 250_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up,
    input  logic              host_hold_rst,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_val,
    input  logic              img_we,
    input  logic [IMG_AW-1:0] img_addr,
    input  logic [7:0]        img_data,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_rwb,
    output logic [7:0]        cpu_data_o,
    output logic              cpu_data_oe,
    output logic              phi2,
    output logic              resb_pull_low
);
    import romemu_pkg::*;

    logic  started;
    logic  rst_assert;
    logic  phi2_w;
    logic  oe_q;
    byte_t rd_byte;

    romemu_rstseq u_rstseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_up    (link_up),
        .host_hold  (host_hold_rst),
        .started    (started),
        .rst_assert (rst_assert)
    );

    romemu_phi2gen #(
        .DIV_W       (DIV_W),
        .DIV_DEFAULT (DIV_DEFAULT)
    ) u_phi2gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (started),
        .div_we  (div_we),
        .div_val (div_val),
        .phi2    (phi2_w)
    );

    romemu_image #(
        .IMG_AW (IMG_AW)
    ) u_image (
        .clk     (clk),
        .wr_en   (img_we && rst_assert),
        .wr_addr (img_addr),
        .wr_data (img_data),
        .rd_addr (cpu_addr[IMG_AW-1:0]),
        .rd_data (rd_byte)
    );

    // Bus drive enable: selected, read cycle, high phase, serving active.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= started && cpu_addr[SEL_BIT] && cpu_rwb && phi2_w;
    end

    assign cpu_data_o    = rd_byte;
    assign cpu_data_oe   = oe_q;
    assign phi2          = phi2_w;
    assign resb_pull_low = rst_assert;

    // R6
    oe_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_data_oe |-> $past(cpu_addr[SEL_BIT]));

    // R7
    oe_read_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_data_oe |-> ($past(cpu_rwb) && $past(phi2_w)));

    // R11
    oe_started_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_data_oe |-> $past(started));
endmodule

// File: tb/bus_rom_emulator_bench.sv
module bus_rom_emulator_bench;
    localparam int IMG_AW = 11;
    localparam int DIV_W  = 28;
    localparam int DEPTH  = 1 << IMG_AW;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              link_up;
    logic              host_hold_rst;
    logic              div_we;
    logic [DIV_W-1:0]  div_val;
    logic              img_we;
    logic [IMG_AW-1:0] img_addr;
    logic [7:0]        img_data;
    logic [15:0]       cpu_addr;
    logic              cpu_rwb;
    logic [7:0]        cpu_data_o;
    logic              cpu_data_oe;
    logic              phi2;
    logic              resb_pull_low;

    logic [7:0] ref_img [DEPTH];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    bus_rom_emulator #(.IMG_AW(IMG_AW), .DIV_W(DIV_W)) u_bus_rom_emulator (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .host_hold_rst(host_hold_rst),
        .div_we(div_we), .div_val(div_val), .img_we(img_we), .img_addr(img_addr),
        .img_data(img_data), .cpu_addr(cpu_addr), .cpu_rwb(cpu_rwb),
        .cpu_data_o(cpu_data_o), .cpu_data_oe(cpu_data_oe), .phi2(phi2),
        .resb_pull_low(resb_pull_low)
    );

    function automatic logic exp_oe(input logic srv, input logic [15:0] a,
                                    input logic rw, input logic p);
        return srv && a[15] && rw && p;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic set_div(input int n);
        @(negedge clk); div_we = 1'b1; div_val = DIV_W'(n);
        @(negedge clk); div_we = 1'b0;
    endtask

    // Random bus cycles, each checked one cycle after it is driven.
    task automatic bus_random(input logic srv, input int n);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            logic [15:0] a;
            logic rw;
            logic p;
            logic e;
            string tag;
            a = 16'($urandom);
            rw = ($urandom % 4) != 0;
            cpu_addr = a; cpu_rwb = rw; p = phi2;
            @(negedge clk);
            e = exp_oe(srv, a, rw, p);
            if (!srv)       tag = "R11";
            else if (!a[15]) tag = "R6";
            else if (!rw || !p) tag = "R7";
            else            tag = "R5";
            check(cpu_data_oe == e, tag, int'(cpu_data_oe), int'(e));
            if (e) check(cpu_data_o == ref_img[a[IMG_AW-1:0]], "R5",
                         int'(cpu_data_o), int'(ref_img[a[IMG_AW-1:0]]));
        end
    endtask

    // Directed read issued in a high phase of phi2.
    task automatic read_at(input logic [15:0] a, input string tag, input logic [7:0] exp);
        @(negedge clk);
        while (phi2 !== 1'b1) @(negedge clk);
        cpu_addr = a; cpu_rwb = 1'b1;
        @(negedge clk);
        check(cpu_data_oe == 1'b1, tag, int'(cpu_data_oe), 1);
        check(cpu_data_o == exp, tag, int'(cpu_data_o), int'(exp));
    endtask

    // Measure one high and one low phase of phi2 in system cycles.
    task automatic measure(input int n);
        int hi;
        int lo;
        set_div(n);
        repeat (4 * n + 4) @(negedge clk);
        while (phi2 !== 1'b0) @(negedge clk);
        while (phi2 !== 1'b1) @(negedge clk);
        hi = 0;
        while (phi2 === 1'b1) begin hi++; @(negedge clk); end
        lo = 0;
        while (phi2 === 1'b0) begin lo++; @(negedge clk); end
        check(hi == n, "R3 high phase", hi, n);
        check(lo == n, "R3 low phase", lo, n);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; link_up = 1'b0; host_hold_rst = 1'b0;
        div_we = 1'b0; div_val = '0; img_we = 1'b0; img_addr = '0; img_data = '0;
        cpu_addr = 16'h8000; cpu_rwb = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(phi2 == 1'b0, "R1 phi2", int'(phi2), 0);
        check(resb_pull_low == 1'b1, "R1 reset line", int'(resb_pull_low), 1);
        check(cpu_data_oe == 1'b0, "R1 bus enable", int'(cpu_data_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(resb_pull_low == 1'b1, "R1 after release", int'(resb_pull_low), 1);

        set_div(3);
        // R11 nothing runs before the link
        begin
            bit moved = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (phi2 !== 1'b0) moved = 1;
            end
            check(!moved, "R11 clock stopped", int'(moved), 0);
        end
        bus_random(1'b0, 30);

        // R2 auto-start
        @(negedge clk); link_up = 1'b1;
        @(negedge clk);
        check(resb_pull_low == 1'b0, "R2 reset released", int'(resb_pull_low), 0);
        begin
            int toggles = 0;
            logic prev = phi2;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (phi2 !== prev) toggles++;
                prev = phi2;
            end
            check(toggles >= 3, "R2 clock running", toggles, 3);
        end

        // R8 hold reset for loading
        @(negedge clk); host_hold_rst = 1'b1;
        @(negedge clk);
        check(resb_pull_low == 1'b1, "R8 hold", int'(resb_pull_low), 1);
        for (int i = 0; i < DEPTH; i++) begin
            ref_img[i] = 8'($urandom);
            img_we = 1'b1; img_addr = IMG_AW'(i); img_data = ref_img[i];
            @(negedge clk);
        end
        img_we = 1'b0;
        read_at(16'h8000 | 16'(12), "R9 load under reset", ref_img[12]);
        host_hold_rst = 1'b0;
        @(negedge clk);
        check(resb_pull_low == 1'b0, "R8 release", int'(resb_pull_low), 0);

        // R9 write while running is ignored
        img_we = 1'b1; img_addr = IMG_AW'(5); img_data = ~ref_img[5];
        @(negedge clk);
        img_we = 1'b0;
        read_at(16'h8005, "R9 ignored write", ref_img[5]);

        bus_random(1'b1, 600);

        // R10 mirroring across the upper half
        for (int k = 0; k < 4; k++) begin
            logic [IMG_AW-1:0] idx;
            idx = IMG_AW'($urandom);
            read_at(16'h8000 | 16'(idx), "R10 base", ref_img[idx]);
            read_at(16'h8000 | 16'(idx) | (16'(k + 1) << IMG_AW), "R10 mirror", ref_img[idx]);
        end
        read_at(16'hFFFF, "R10 top", ref_img[DEPTH-1]);

        measure(3);
        measure(7);

        // R4 zero divider stops the clock low
        set_div(0);
        @(negedge clk);
        begin
            bit moved = 0;
            for (int i = 0; i < 25; i++) begin
                if (phi2 !== 1'b0) moved = 1;
                @(negedge clk);
            end
            check(!moved, "R4 clock parked low", int'(moved), 0);
        end
        bus_random(1'b1, 40);

        done = 1;
        summary();
    end
endmodule